// File: doc/BRIEF.md
# Adaptive Iteration and Termination Controller

This controller paces an iterative LDPC decoder frame by frame. A frame begins when the controller accepts a start request while idle. It then issues one iteration-start pulse, waits for the message-passing datapath to signal that the iteration has finished, and captures the per-check syndrome bits that come with that signal. In the following cycle it counts the unsatisfied checks and decides what happens next. It can stop with success, stop with failure at the iteration cap, run another iteration in the current mode, or run another iteration after promoting the datapath from the cheap min-sum mode to the stronger belief-propagation mode.

A mode output selects the algorithm. The promotion is triggered when the completed-iteration count passes one programmable threshold, or when the unsatisfied-check count passes another. Once promoted, the mode stays strong until the frame ends. A datapath clock-enable output is high while a frame is in flight and drops as soon as the frame terminates, so the idle datapath is clock-gated. At the end of each frame the controller emits a one-cycle done pulse and holds the outcome, the number of iterations used, and whether a promotion happened.

Top module: `iter_ctrl`

## Requirements
- R1: After reset, iter_start, done, success, fail, dp_clk_en and strong_mode are 0 and iters_used is 0.
- R2: A frame is accepted only while the controller is idle. A frame_start seen during a frame has no effect on that frame's iterations, mode or outcome.
- R3: iter_start is high for exactly one cycle per iteration. The first pulse comes in the cycle after frame_start is sampled. Each later pulse comes two cycles after the cycle in which iter_done is sampled, if the frame continues.
- R4: strong_mode is 0 (min-sum) at the first iteration of every frame, even if the previous frame ended in strong mode.
- R5: After a non-terminal iteration, if the number of completed iterations is strictly greater than iter_thr, strong_mode becomes 1 and stays 1 for every remaining iteration of the frame.
- R6: After a non-terminal iteration, if the number of 1 bits in the captured syndrome is strictly greater than unsat_thr, strong_mode becomes 1 and stays 1 for the rest of the frame.
- R7: When the captured syndrome is all zeros, the frame ends with success=1 and fail=0, and no further iter_start is issued.
- R8: When the completed-iteration count reaches max_iter and the syndrome is non-zero, the frame ends with fail=1 and success=0. A max_iter of 0 behaves as 1, so at least one iteration always runs.
- R9: dp_clk_en is 1 from the cycle after acceptance through the last evaluation. It is 0 in the done cycle and while idle.
- R10: done is a one-cycle pulse in the cycle after the terminating evaluation. success, fail and iters_used (the number of completed iterations) hold their values until the next frame is accepted.
- R11: switched is 1 at done exactly when strong_mode was raised during the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Request to begin a new frame |
| max_iter | input | ITW | Iteration cap (0 acts as 1) |
| iter_thr | input | ITW | Iteration count above which strong mode is used |
| unsat_thr | input | PW | Unsatisfied-check count above which strong mode is used |
| iter_done | input | 1 | Datapath finished the current iteration |
| syndrome | input | NCHK | Per-check syndrome bits, valid with iter_done |
| iter_start | output | 1 | One-cycle pulse launching an iteration |
| strong_mode | output | 1 | 0 selects min-sum, 1 selects belief propagation |
| dp_clk_en | output | 1 | Clock enable for the decoding datapath |
| done | output | 1 | One-cycle end-of-frame pulse |
| success | output | 1 | Frame ended on a zero syndrome |
| fail | output | 1 | Frame ended at the iteration cap |
| iters_used | output | ITW | Completed iterations of the last frame |
| switched | output | 1 | Strong mode was entered during the frame |

## Verification
The embedded assertions check several properties on every cycle:
- iter_start and done are single-cycle pulses.
- The mode is cleared on acceptance and never falls back within a frame.
- The clock enable is low whenever done is high.
- Exactly one of success and fail accompanies done.
- A successful frame really captured a zero syndrome.
- iters_used never exceeds the effective cap.

Other behaviours can only be shown by the bench's scenarios. These are the exact iteration at which each threshold promotes the mode, the strict-greater boundaries of both thresholds, the cap of zero, the absence of further iterations after success, and the fact that start requests during a frame are ignored.

// File: rtl/iter_ctrl.sv
module iter_ctrl #(
  parameter int NCHK = 16,
  parameter int ITW  = 6,
  parameter int PW   = $clog2(NCHK + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic [ITW-1:0]  max_iter,
  input  logic [ITW-1:0]  iter_thr,
  input  logic [PW-1:0]   unsat_thr,
  input  logic            iter_done,
  input  logic [NCHK-1:0] syndrome,
  output logic            iter_start,
  output logic            strong_mode,
  output logic            dp_clk_en,
  output logic            done,
  output logic            success,
  output logic            fail,
  output logic [ITW-1:0]  iters_used,
  output logic            switched
);

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_WAIT, S_EVAL, S_DONE} st_t;

  st_t            state;
  logic [ITW-1:0] count;
  logic [NCHK-1:0] syn_q;
  logic [PW-1:0]  unsat;
  logic [ITW-1:0] eff_max;

  always_comb begin
    unsat = '0;
    for (int i = 0; i < NCHK; i++) unsat = unsat + PW'(syn_q[i]);
  end

  assign eff_max = (max_iter == '0) ? ITW'(1) : max_iter;

  wire syn_zero  = (unsat == '0);
  wire at_cap    = (count >= eff_max);
  wire go_strong = (count > iter_thr) || (unsat > unsat_thr);
  wire accept    = (state == S_IDLE) && frame_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      count       <= '0;
      syn_q       <= '0;
      strong_mode <= 1'b0;
      switched    <= 1'b0;
      success     <= 1'b0;
      fail        <= 1'b0;
      dp_clk_en   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (frame_start) begin
          state       <= S_RUN;
          count       <= '0;
          strong_mode <= 1'b0;
          switched    <= 1'b0;
          success     <= 1'b0;
          fail        <= 1'b0;
          dp_clk_en   <= 1'b1;
        end
        S_RUN: state <= S_WAIT;
        S_WAIT: if (iter_done) begin
          syn_q <= syndrome;
          count <= count + 1'b1;
          state <= S_EVAL;
        end
        S_EVAL: begin
          if (syn_zero) begin
            success   <= 1'b1;
            dp_clk_en <= 1'b0;
            state     <= S_DONE;
          end else if (at_cap) begin
            fail      <= 1'b1;
            dp_clk_en <= 1'b0;
            state     <= S_DONE;
          end else begin
            if (go_strong) begin
              strong_mode <= 1'b1;
              switched    <= 1'b1;
            end
            state <= S_RUN;
          end
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign iter_start = (state == S_RUN);
  assign done       = (state == S_DONE);
  assign iters_used = count;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) iter_start |=> !iter_start); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_NEW_FRAME_MINSUM: assert property (@(posedge clk) disable iff (!rst_n) accept |=> !strong_mode); // R4
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (strong_mode && !accept) |=> strong_mode); // R5
  AST_GATED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !dp_clk_en); // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) done |-> $onehot({success, fail})); // R10
  AST_SUCCESS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && success) |-> (syn_q == '0)); // R7
  AST_ITER_CAP: assert property (@(posedge clk) disable iff (!rst_n) done |-> (iters_used <= eff_max)); // R8
  AST_SWITCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n) done |-> (switched == strong_mode)); // R11

endmodule

// File: tb/tb_iter_ctrl.sv
module tb_iter_ctrl;
  localparam int NCHK = 16;
  localparam int ITW  = 6;
  localparam int PW   = $clog2(NCHK + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [ITW-1:0] max_iter = '0;
  logic [ITW-1:0] iter_thr = '0;
  logic [PW-1:0]  unsat_thr = '0;
  logic iter_done = 1'b0;
  logic [NCHK-1:0] syndrome = '0;
  logic iter_start, strong_mode, dp_clk_en, done, success, fail, switched;
  logic [ITW-1:0] iters_used;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  iter_ctrl #(.NCHK(NCHK), .ITW(ITW)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .max_iter(max_iter), .iter_thr(iter_thr), .unsat_thr(unsat_thr),
    .iter_done(iter_done), .syndrome(syndrome),
    .iter_start(iter_start), .strong_mode(strong_mode), .dp_clk_en(dp_clk_en),
    .done(done), .success(success), .fail(fail),
    .iters_used(iters_used), .switched(switched)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // columns: max_iter, iter_thr, unsat_thr, zero_at (0 = never), unsat pop, poke frame_start
  localparam int NV = 10;
  localparam int VEC [NV][6] = '{
    '{10, 20, 16, 3, 2, 0},  // R7 success at iteration 3, no switch
    '{ 5, 20, 16, 0, 2, 0},  // R8 cap failure
    '{ 8,  2, 16, 5, 1, 0},  // R5 switch after iteration 3
    '{ 6, 20,  3, 0, 4, 0},  // R6 switch on unsat count, R4 after a strong frame
    '{ 6, 20,  4, 0, 4, 0},  // R6 boundary: equal does not switch
    '{ 4,  3, 16, 0, 1, 0},  // R5 boundary: count equal to thr at cap
    '{ 0, 20, 16, 0, 1, 0},  // R8 cap of zero acts as one
    '{10, 20, 16, 1, 1, 0},  // R7 immediate success
    '{ 3,  0, 16, 0, 1, 0},  // R5 thr zero switches after first
    '{ 7,  1,  2, 4, 3, 1}   // R2 frame_start during frame ignored
  };

  task automatic run_frame(input int mi, input int it, input int ut,
                           input int zero_at, input int pop, input int poke);
    int  effmax;
    bit  exp_strong;
    bit  exp_sw;
    effmax = (mi == 0) ? 1 : mi;
    exp_strong = 0;
    exp_sw = 0;
    max_iter  = ITW'(mi);
    iter_thr  = ITW'(it);
    unsat_thr = PW'(ut);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int n = 1; n <= 64; n++) begin
      chk(iter_start == 1'b1, "R3 iter_start", iter_start, 1);
      chk(strong_mode == exp_strong, (n == 1) ? "R4 first mode" : "R5/R6 mode", strong_mode, exp_strong);
      chk(dp_clk_en == 1'b1, "R9 clk_en running", dp_clk_en, 1);
      @(negedge clk);
      chk(iter_start == 1'b0, "R3 pulse width", iter_start, 0);
      if (poke != 0) begin
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
      end
      iter_done = 1'b1;
      syndrome  = (n == zero_at) ? '0 : NCHK'((32'd1 << pop) - 1);
      @(negedge clk);
      iter_done = 1'b0;
      syndrome  = '0;
      @(negedge clk);
      if (n == zero_at || n >= effmax) begin
        chk(done == 1'b1, "R10 done pulse", done, 1);
        chk(iter_start == 1'b0, "R7 no more iterations", iter_start, 0);
        chk(success == (n == zero_at), "R7 success", success, int'(n == zero_at));
        chk(fail == (n != zero_at), "R8 fail", fail, int'(n != zero_at));
        chk(int'(iters_used) == n, "R10 iters_used", iters_used, n);
        chk(switched == exp_sw, "R11 switched", switched, exp_sw);
        chk(dp_clk_en == 1'b0, "R9 clk_en gated", dp_clk_en, 0);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", done, 0);
        chk(int'(iters_used) == n, "R10 iters_used held", iters_used, n);
        chk(success == (n == zero_at), "R10 outcome held", success, int'(n == zero_at));
        break;
      end
      if (n > it || pop > ut) begin
        exp_strong = 1;
        exp_sw = 1;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(iter_start == 0 && done == 0, "R1 reset pulses", iter_start, 0);
    chk(dp_clk_en == 0 && strong_mode == 0, "R1 reset enables", dp_clk_en, 0);
    chk(success == 0 && fail == 0 && iters_used == 0, "R1 reset status", iters_used, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dp_clk_en == 0, "R9 idle gated", dp_clk_en, 0);

    for (int v = 0; v < NV; v++)
      run_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);

    // R2: stray iter_done while idle starts nothing
    iter_done = 1'b1;
    syndrome  = '1;
    @(negedge clk);
    iter_done = 1'b0;
    @(negedge clk);
    chk(iter_start == 0 && done == 0, "R2 idle ignores iter_done", iter_start, 0);
    chk(dp_clk_en == 0, "R9 idle after frames", dp_clk_en, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule